// File: doc/BRIEF.md
# RAM-Backed Tapped Delay Line

This block delays a stream of W-bit words and shows several copies of that stream at evenly spaced depths. The words are kept in a circular buffer in a simple dual-port memory, not in a chain of flip-flops. A write pointer walks the buffer. Each tap reads the buffer at a fixed distance behind the pointer. A long delay therefore costs memory words rather than logic cells, which suits FIR delay lines, feedback shift structures and line buffers.

The parameters are the word width `WORD_W`, the tap count `TAP_CNT` and the tap spacing `TAP_GAP`. The buffer holds `TAP_CNT*TAP_GAP` words. A spacing below three is rejected at elaboration. Words enter on every rising clock edge at which `shift_en` is high. There is no back-pressure: the producer owns the enable and the block accepts every enabled word. An asynchronous clear empties the delay line logically without rewriting the memory array.

Top module: `ram_tap_delay`

## Requirements
- R1: While `clr` is high, and right after it is released, `data_out` and every tap read zero.
- R2: Count the newest word in the line as position 1. After any enabled edge, tap k (k = 0 .. TAP_CNT-1) shows the word at position (k+1)*TAP_GAP. Tap k occupies bits [k*WORD_W +: WORD_W] of `taps`, so the deepest tap sits in the top word.
- R3: `data_out` always equals the most significant word of `taps`.
- R4: An edge with `shift_en` low neither shifts nor changes any output, whatever `data_in` carries.
- R5: Tap k reads zero until at least (k+1)*TAP_GAP words have been shifted in since the last clear.
- R6: Raising `clr` forces every output to zero at once, without waiting for a clock edge. Words shifted in after the clear never expose data from before it.
- R7: A tap value is valid directly after the enabled edge that produces it, with no added output stage. A word shifted in at edge e first appears on tap k right after the enabled edge e+(k+1)*TAP_GAP-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| shift_en | input | 1 | Clock enable; high to shift one word |
| data_in | input | WORD_W | Word entering the line |
| data_out | output | WORD_W | Copy of the deepest tap |
| taps | output | WORD_W*TAP_CNT | All taps packed, tap 0 in the low word |

## Verification
A pointer that skips or wraps at the wrong place misaligns every tap against the reference history within one trip round the buffer. A read address off by one shows up as a tap one word early or late on the very next enabled edge. A fill count that is wrong exposes stale or nonzero words during the first TAP_CNT*TAP_GAP shifts after a clear. A read register that updates while the enable is low changes the taps on the first idle cycle.

// File: rtl/ram_tap_delay_pkg.sv
package ram_tap_delay_pkg;

  // Sum of two indices folded back into [0, depth); both inputs are below depth.
  function automatic int unsigned wrap_add(input int unsigned a, input int unsigned b,
                                           input int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/ram_tap_delay_ptr.sv
module ram_tap_delay_ptr
  import ram_tap_delay_pkg::*;
#(
  parameter int unsigned TAP_CNT = 4,
  parameter int unsigned TAP_GAP = 3,
  localparam int unsigned DEPTH  = TAP_CNT * TAP_GAP,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  shift_en,
  output logic [AW-1:0]         wr_ptr,
  output logic [TAP_CNT*AW-1:0] rd_ptr
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      wr_ptr <= '0;
    end else if (shift_en) begin
      wr_ptr <= AW'(wrap_add(int'(wr_ptr), 1, DEPTH));
    end
  end

  // The read is synchronous, so each address points at the word that
  // the tap must show after the edge that samples it.
  for (genvar k = 0; k < TAP_CNT; k++) begin : g_rd
    localparam int unsigned OFFS = DEPTH - (k + 1) * TAP_GAP + 1;
    assign rd_ptr[k*AW +: AW] = AW'(wrap_add(int'(wr_ptr), OFFS, DEPTH));
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (clr)
    int'(wr_ptr) < DEPTH);  // R2

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (clr)
    (shift_en && int'(wr_ptr) == DEPTH - 1) |=> wr_ptr == '0);  // R2

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (clr)
    !shift_en |=> $stable(wr_ptr));  // R4

endmodule

// File: rtl/ram_tap_delay_mem.sv
module ram_tap_delay_mem #(
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned TAP_CNT = 4,
  parameter int unsigned TAP_GAP = 3,
  localparam int unsigned DEPTH  = TAP_CNT * TAP_GAP,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      shift_en,
  input  logic [AW-1:0]             wr_ptr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [TAP_CNT*AW-1:0]     rd_ptr,
  output logic [TAP_CNT*WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (shift_en) begin
      store[wr_ptr] <= wr_data;
    end
  end

  for (genvar k = 0; k < TAP_CNT; k++) begin : g_port
    always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
        rd_data[k*WORD_W +: WORD_W] <= '0;
      end else if (shift_en) begin
        rd_data[k*WORD_W +: WORD_W] <= store[rd_ptr[k*AW +: AW]];
      end
    end

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (clr)
      shift_en |-> rd_ptr[k*AW +: AW] != wr_ptr);  // R7
  end

endmodule

// File: rtl/ram_tap_delay_fill.sv
module ram_tap_delay_fill #(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          shift_en,
  output logic [FW-1:0] fill
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      fill <= '0;
    end else if (shift_en && int'(fill) < DEPTH) begin
      fill <= fill + 1'b1;
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (clr)
    int'(fill) <= DEPTH);  // R5

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (clr)
    (shift_en && int'(fill) < DEPTH) |=> fill == $past(fill) + 1'b1);  // R5

endmodule

// File: rtl/ram_tap_delay.sv
module ram_tap_delay #(
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned TAP_CNT = 4,
  parameter int unsigned TAP_GAP = 3
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      shift_en,
  input  logic [WORD_W-1:0]         data_in,
  output logic [WORD_W-1:0]         data_out,
  output logic [WORD_W*TAP_CNT-1:0] taps
);

  localparam int unsigned DEPTH = TAP_CNT * TAP_GAP;
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned FW    = $clog2(DEPTH + 1);

  if (TAP_GAP < 3) begin : g_bad_gap
    $error("ram_tap_delay: TAP_GAP must be 3 or more");
  end

  logic [AW-1:0]             wr_ptr;
  logic [TAP_CNT*AW-1:0]     rd_ptr;
  logic [TAP_CNT*WORD_W-1:0] rd_data;
  logic [FW-1:0]             fill;

  ram_tap_delay_ptr #(.TAP_CNT(TAP_CNT), .TAP_GAP(TAP_GAP)) u_ptr (
    .clk(clk), .clr(clr), .shift_en(shift_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  ram_tap_delay_mem #(.WORD_W(WORD_W), .TAP_CNT(TAP_CNT), .TAP_GAP(TAP_GAP)) u_mem (
    .clk(clk), .clr(clr), .shift_en(shift_en), .wr_ptr(wr_ptr), .wr_data(data_in),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  ram_tap_delay_fill #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .clr(clr), .shift_en(shift_en), .fill(fill)
  );

  // A tap stays masked until the history behind it holds real words.
  for (genvar k = 0; k < TAP_CNT; k++) begin : g_mask
    localparam int unsigned NEED = (k + 1) * TAP_GAP;
    assign taps[k*WORD_W +: WORD_W] =
      (int'(fill) >= NEED) ? rd_data[k*WORD_W +: WORD_W] : '0;
  end

  assign data_out = taps[WORD_W*(TAP_CNT-1) +: WORD_W];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    !shift_en |=> $stable(taps));  // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clr |-> (taps == '0 && data_out == '0));  // R6

  AST_DEEP_MASKED: assert property (@(posedge clk) disable iff (clr)
    (int'(fill) < DEPTH) |-> data_out == '0);  // R5

endmodule

// File: tb/ram_tap_delay_tb.sv
module ram_tap_delay_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 8;
  localparam int unsigned N = 4;
  localparam int unsigned M = 3;
  localparam int unsigned D = N * M;
  localparam int unsigned ROWS = 20;

  // Stimulus rows: {enable, word}
  localparam logic [W:0] STIM [ROWS] = '{
    9'h1_A1, 9'h1_B2, 9'h0_FF, 9'h1_C3, 9'h1_D4, 9'h0_00, 9'h0_55, 9'h1_E5,
    9'h1_F6, 9'h1_07, 9'h0_99, 9'h1_18, 9'h1_29, 9'h1_3A, 9'h1_4B, 9'h0_77,
    9'h1_5C, 9'h1_6D, 9'h1_7E, 9'h1_8F
  };

  logic             clk = 1'b0;
  logic             clr = 1'b0;
  logic             shift_en = 1'b0;
  logic [W-1:0]     data_in = '0;
  logic [W-1:0]     data_out;
  logic [W*N-1:0]   taps;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] hist [D];
  int           count = 0;

  ram_tap_delay #(.WORD_W(W), .TAP_CNT(N), .TAP_GAP(M)) u_dut (
    .clk(clk), .clr(clr), .shift_en(shift_en), .data_in(data_in),
    .data_out(data_out), .taps(taps)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W*N-1:0] model_taps();
    logic [W*N-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) begin
      if (count >= (k + 1) * M) v[k*W +: W] = hist[(k + 1) * M - 1];
    end
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < D; i++) hist[i] = '0;
    count = 0;
  endtask

  task automatic check(input string req, input logic [W*N-1:0] got, input logic [W*N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_out(input string req);
    check(req, taps, model_taps());
    check({req, "/R3"}, {{(W*N-W){1'b0}}, data_out}, {{(W*N-W){1'b0}}, taps[W*N-1 -: W]});
  endtask

  task automatic cycle(input logic e, input logic [W-1:0] d);
    shift_en = e;
    data_in  = d;
    @(posedge clk);
    #1;
    if (e) begin
      for (int i = D - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      if (count < D) count++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W*N-1:0] held;
    model_clear();
    #1 clr = 1'b1;
    #(CLK_PERIOD * 2);
    check("R1 during clear", taps, '0);
    @(negedge clk);
    clr = 1'b0;
    #1;
    check("R1 after release", taps, '0);
    check("R1 data_out", {24'h0, data_out}, '0);

    // Words 1..14: partial fill then full line
    for (int w = 1; w <= 14; w++) begin
      cycle(1'b1, W'(w));
      check_out("R2 R7 fill sequence");
      if (w == 2)  check("R5 two words", taps, 32'h0000_0000);
      if (w == 3)  check("R5 R7 first tap", taps, 32'h0000_0001);
      if (w == 11) check("R5 deepest still empty", {24'h0, data_out}, '0);
      if (w == 12) check("R2 full line", taps, 32'h0104_070A);
      if (w == 13) check("R2 next shift", taps, 32'h0205_080B);
      if (w == 14) check("R2 second shift", taps, 32'h0306_090C);
    end

    // Idle edges with changing input
    held = taps;
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, W'(8'hE0 + i));
      check("R4 hold", taps, held);
    end

    // Table-driven mixed pattern
    for (int r = 0; r < ROWS; r++) begin
      cycle(STIM[r][W], STIM[r][W-1:0]);
      check_out("R2 R4 table");
    end

    // Asynchronous clear between edges
    @(negedge clk);
    clr = 1'b1;
    #1;
    check("R6 immediate clear", taps, '0);
    check("R6 data_out clear", {24'h0, data_out}, '0);
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    cycle(1'b1, 8'h91);
    cycle(1'b1, 8'h92);
    check("R6 no stale history", taps, '0);
    cycle(1'b1, 8'h93);
    check("R6 first word after clear", taps, 32'h0000_0091);
    for (int i = 0; i < D; i++) begin
      cycle(1'b1, W'(8'h40 + i));
      check_out("R6 refill");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule